// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block turns virtual addresses into physical addresses for an instruction fetch, a load or a store. It holds a small, fully associative set of translation entries. The only other state is an address-space register, a wired-count register and a free-running replacement counter. The low 12 bits of an address are the page offset and pass through unchanged. The upper bits form the virtual page number. That number is compared against every entry, together with the current address-space identifier. An entry marked global ignores the identifier.

A lookup answers one cycle after its request. On a hit with usable permissions the unit returns the frame number joined to the offset, and reports whether the access may use the cache. A miss raises a refill exception. A hit on an invalid entry raises an invalid exception. A store to a page that is not writable raises a modify exception. On any of these faults the faulting virtual address is latched for the handler. Software services a miss by writing an entry through the write port, either at an explicit index or at the index given by the replacement counter. The counter never points below the wired count, so the entries under that count are protected from random replacement.

Top module: `soft_tlb`

## Requirements
- R1: A lookup request answers on `rsp_valid` exactly one cycle later. On a hit, `rsp_paddr` is the selected entry's frame number in bits 31:12 and the request's address bits 11:0 in bits 11:0.
- R2: An entry matches when its page number equals address bits 31:12 and either its global bit is set or its identifier equals the address-space register. The register is loaded by `asid_we` and is 0 after reset.
- R3: When no entry matches, `rsp_refill` is 1, `rsp_invalid`, `rsp_modify` and `rsp_uncached` are 0, and `rsp_paddr` is 0.
- R4: A hit on an entry whose valid bit is 0 sets `rsp_invalid`. This applies to both loads and stores.
- R5: A store (`req_store`=1) that hits a valid entry whose dirty bit is 0 sets `rsp_modify`. A load on the same entry raises no exception.
- R6: `rsp_uncached` equals the no-cache bit of the selected entry on a hit (1 = uncacheable, 0 = cacheable), and is 0 on a miss.
- R7: On any refill, invalid or modify fault, `bad_vaddr` takes the full faulting virtual address. A lookup without a fault leaves it unchanged. It is 0 after reset.
- R8: `ent_we` with `ent_random`=0 writes all entry fields at `ent_index`, replacing that entry's previous contents.
- R9: `ent_we` with `ent_random`=1 writes at the index shown on `rand_idx` in that cycle. `rand_idx` never falls below the wired count. With a fixed wired count W, it steps down by one each cycle and wraps from W back to 15. It is 15 after reset.
- R10: If several entries match, the lowest-indexed one supplies the translation and `rsp_multihit` is 1. Otherwise `rsp_multihit` is 0.
- R11: After reset no entry matches any address, `rsp_valid` is 0 and the wired count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| asid_we | input | 1 | Load the address-space register |
| asid_wdata | input | 8 | New address-space identifier |
| wired_we | input | 1 | Load the wired count |
| wired_wdata | input | 4 | New wired count |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | Request is a store |
| ent_we | input | 1 | Write an entry |
| ent_random | input | 1 | 1: write at `rand_idx`, 0: write at `ent_index` |
| ent_index | input | 4 | Explicit entry index |
| ent_vpn | input | 20 | Entry page number |
| ent_asid | input | 8 | Entry address-space identifier |
| ent_global | input | 1 | Entry ignores the identifier |
| ent_pfn | input | 20 | Entry frame number |
| ent_nocache | input | 1 | Entry is uncacheable |
| ent_dirty | input | 1 | Entry is writable |
| ent_valid | input | 1 | Entry is valid |
| rand_idx | output | 4 | Current replacement index |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_uncached | output | 1 | Access must bypass the cache |
| rsp_refill | output | 1 | Refill exception (no match) |
| rsp_invalid | output | 1 | Invalid-entry exception |
| rsp_modify | output | 1 | Store to non-writable page |
| rsp_multihit | output | 1 | More than one entry matched |
| bad_vaddr | output | 32 | Last faulting virtual address |

## Verification
Several entries matching one address is the hardest case to reach. Software that behaves correctly never creates it, and it only shows up when two writes leave the same page number under compatible identifiers, or when a global entry overlaps a private one. The bench builds this directly with two indexed writes of one page at different indices. The random phase also draws page numbers and identifiers from small pools, so that overlaps arise often, including global/private pairs. A second hard case is a random-select write whose target has to be inferred. The bench captures `rand_idx` just before the write and then proves where the entry landed by overwriting that index explicitly.

// File: rtl/soft_tlb.sv
module soft_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asid_we,
  input  logic [ASID_W-1:0] asid_wdata,
  input  logic              wired_we,
  input  logic [IDX_W-1:0]  wired_wdata,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_store,
  input  logic              ent_we,
  input  logic              ent_random,
  input  logic [IDX_W-1:0]  ent_index,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic              ent_global,
  input  logic [PFN_W-1:0]  ent_pfn,
  input  logic              ent_nocache,
  input  logic              ent_dirty,
  input  logic              ent_valid,
  output logic [IDX_W-1:0]  rand_idx,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_uncached,
  output logic              rsp_refill,
  output logic              rsp_invalid,
  output logic              rsp_modify,
  output logic              rsp_multihit,
  output logic [VA_W-1:0]   bad_vaddr
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

  logic [VPN_W-1:0]  e_vpn  [ENTRIES];
  logic [ASID_W-1:0] e_asid [ENTRIES];
  logic [PFN_W-1:0]  e_pfn  [ENTRIES];
  logic [ENTRIES-1:0] e_g, e_n, e_d, e_v, e_used;

  logic [ASID_W-1:0] asid_q;
  logic [IDX_W-1:0]  wired_q, rnd_q;

  assign rand_idx = (rnd_q < wired_q) ? TOP : rnd_q;
  wire [IDX_W-1:0] wr_idx = ent_random ? rand_idx : ent_index;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asid_q  <= '0;
      wired_q <= '0;
      rnd_q   <= TOP;
    end else begin
      if (asid_we)  asid_q  <= asid_wdata;
      if (wired_we) wired_q <= wired_wdata;
      rnd_q <= (rnd_q <= wired_q) ? TOP : rnd_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) e_used <= '0;
    else if (ent_we) e_used[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ent_we) begin
      e_vpn[wr_idx]  <= ent_vpn;
      e_asid[wr_idx] <= ent_asid;
      e_pfn[wr_idx]  <= ent_pfn;
      e_g[wr_idx]    <= ent_global;
      e_n[wr_idx]    <= ent_nocache;
      e_d[wr_idx]    <= ent_dirty;
      e_v[wr_idx]    <= ent_valid;
    end
  end

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:OFF_W];
  logic [ENTRIES-1:0] hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit[i] = e_used[i] && (e_vpn[i] == req_vpn) &&
                    (e_g[i] || (e_asid[i] == asid_q));
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit[i]) sel = IDX_W'(i);
  end

  wire any_hit  = |hit;
  wire multi    = (hit & (hit - 1'b1)) != '0;
  wire f_inval  = any_hit && !e_v[sel];
  wire f_mod    = any_hit && e_v[sel] && req_store && !e_d[sel];
  wire fault    = !any_hit || f_inval || f_mod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_uncached <= 1'b0;
      rsp_refill   <= 1'b0;
      rsp_invalid  <= 1'b0;
      rsp_modify   <= 1'b0;
      rsp_multihit <= 1'b0;
      bad_vaddr    <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_paddr    <= (req_valid && any_hit) ? {e_pfn[sel], req_vaddr[OFF_W-1:0]} : '0;
      rsp_uncached <= req_valid && any_hit && e_n[sel];
      rsp_refill   <= req_valid && !any_hit;
      rsp_invalid  <= req_valid && f_inval;
      rsp_modify   <= req_valid && f_mod;
      rsp_multihit <= req_valid && multi;
      if (req_valid && fault) bad_vaddr <= req_vaddr;
    end
  end

  p_resp_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && any_hit) |=> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));
  p_miss_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_refill |-> (!rsp_invalid && !rsp_modify && !rsp_uncached && rsp_paddr == '0));
  p_modify_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_modify |-> (!rsp_invalid && !rsp_refill));
  p_bad_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fault) |=> (bad_vaddr == $past(req_vaddr)));
  p_bad_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && fault) |=> $stable(bad_vaddr));
  p_rand_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rand_idx >= wired_q);
  p_multi_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multihit |-> (rsp_valid && !rsp_refill));
endmodule

// File: tb/soft_tlb_test.sv
module soft_tlb_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic asid_we = 0, wired_we = 0, req_valid = 0, req_store = 0;
  logic [7:0] asid_wdata = 0;
  logic [3:0] wired_wdata = 0;
  logic [31:0] req_vaddr = 0;
  logic ent_we = 0, ent_random = 0, ent_global = 0, ent_nocache = 0, ent_dirty = 0, ent_valid = 0;
  logic [3:0] ent_index = 0;
  logic [19:0] ent_vpn = 0, ent_pfn = 0;
  logic [7:0] ent_asid = 0;
  logic [3:0] rand_idx;
  logic rsp_valid, rsp_uncached, rsp_refill, rsp_invalid, rsp_modify, rsp_multihit;
  logic [31:0] rsp_paddr, bad_vaddr;

  soft_tlb uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;

  logic [19:0] m_vpn [16];
  logic [7:0]  m_asid [16];
  logic [19:0] m_pfn [16];
  logic m_g [16], m_n [16], m_d [16], m_v [16], m_used [16];
  logic [7:0]  m_cur_asid = 0;
  logic [3:0]  m_wired = 0;
  logic [31:0] m_bad = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic set_asid(input logic [7:0] a);
    @(negedge clk); asid_we = 1; asid_wdata = a;
    @(negedge clk); asid_we = 0; m_cur_asid = a;
  endtask

  task automatic set_wired(input logic [3:0] w);
    @(negedge clk); wired_we = 1; wired_wdata = w;
    @(negedge clk); wired_we = 0; m_wired = w;
  endtask

  task automatic put(input bit rnd, input logic [3:0] idx, input logic [19:0] vpn, input logic [7:0] as,
                     input bit g, input logic [19:0] pfn, input bit n, input bit d, input bit v,
                     output logic [3:0] used_idx);
    @(negedge clk);
    used_idx = rnd ? rand_idx : idx;
    if (rnd) chk(rand_idx >= m_wired, "R9 rand_idx below wired", 64'(rand_idx), 64'(m_wired));
    ent_we = 1; ent_random = rnd; ent_index = idx; ent_vpn = vpn; ent_asid = as; ent_global = g;
    ent_pfn = pfn; ent_nocache = n; ent_dirty = d; ent_valid = v;
    @(negedge clk); ent_we = 0; ent_random = 0;
    m_vpn[used_idx] = vpn; m_asid[used_idx] = as; m_pfn[used_idx] = pfn;
    m_g[used_idx] = g; m_n[used_idx] = n; m_d[used_idx] = d; m_v[used_idx] = v; m_used[used_idx] = 1;
  endtask

  task automatic look(input logic [31:0] va, input bit st, input string tag);
    int sel = -1, cnt = 0;
    logic [31:0] e_pa;
    bit e_ref, e_inv, e_mod, e_unc;
    for (int i = 15; i >= 0; i--)
      if (m_used[i] && m_vpn[i] == va[31:12] && (m_g[i] || m_asid[i] == m_cur_asid)) begin
        sel = i; cnt++;
      end
    e_ref = (sel < 0);
    e_pa  = e_ref ? 32'h0 : {m_pfn[sel], va[11:0]};
    e_inv = !e_ref && !m_v[sel];
    e_mod = !e_ref && m_v[sel] && st && !m_d[sel];
    e_unc = !e_ref && m_n[sel];
    if (e_ref || e_inv || e_mod) m_bad = va;
    @(negedge clk); req_valid = 1; req_vaddr = va; req_store = st;
    @(negedge clk); req_valid = 0; req_store = 0;
    chk(rsp_valid === 1'b1, {tag, " R1 rsp_valid"}, 64'(rsp_valid), 1);
    chk(rsp_paddr === e_pa, {tag, " R1 paddr"}, 64'(rsp_paddr), 64'(e_pa));
    chk(rsp_refill === e_ref, {tag, " R3 refill"}, 64'(rsp_refill), 64'(e_ref));
    chk(rsp_invalid === e_inv, {tag, " R4 invalid"}, 64'(rsp_invalid), 64'(e_inv));
    chk(rsp_modify === e_mod, {tag, " R5 modify"}, 64'(rsp_modify), 64'(e_mod));
    chk(rsp_uncached === e_unc, {tag, " R6 uncached"}, 64'(rsp_uncached), 64'(e_unc));
    chk(rsp_multihit === (cnt > 1), {tag, " R10 multihit"}, 64'(rsp_multihit), 64'(cnt > 1));
    chk(bad_vaddr === m_bad, {tag, " R7 bad_vaddr"}, 64'(bad_vaddr), 64'(m_bad));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] ix, prev;
    logic [31:0] seed;
    for (int i = 0; i < 16; i++) m_used[i] = 0;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(rsp_valid === 0, "R11 rsp_valid after reset", 64'(rsp_valid), 0);
    chk(rand_idx === 4'd14 || rand_idx === 4'd15, "R9 rand_idx near top after reset", 64'(rand_idx), 15);
    chk(bad_vaddr === 0, "R7 bad_vaddr reset", 64'(bad_vaddr), 0);
    look(32'h0000_0123, 0, "R11 empty");

    // R8/R1 indexed write and hit
    put(0, 4'd2, 20'h00010, 8'h00, 0, 20'hABCDE, 0, 1, 1, ix);
    look(32'h0001_0FFF, 1, "R1 hit");
    // R2 asid mismatch vs global
    set_asid(8'h05);
    look(32'h0001_0004, 0, "R2 asid miss");
    put(0, 4'd6, 20'h00020, 8'h77, 1, 20'h12345, 1, 1, 1, ix);
    look(32'h0002_0ABC, 0, "R2 global R6 uncached");
    // R4 invalid, R5 modify
    put(0, 4'd7, 20'h00030, 8'h05, 0, 20'h00333, 0, 0, 0, ix);
    look(32'h0003_0010, 0, "R4 invalid load");
    put(0, 4'd8, 20'h00040, 8'h05, 0, 20'h00444, 0, 0, 1, ix);
    look(32'h0004_0020, 1, "R5 store clean");
    look(32'h0004_0024, 0, "R5 load clean");
    // R8 overwrite
    put(0, 4'd8, 20'h00041, 8'h05, 0, 20'h00555, 0, 1, 1, ix);
    look(32'h0004_0028, 0, "R8 old gone");
    look(32'h0004_1028, 1, "R8 new");
    // R10 multi-hit
    put(0, 4'd9, 20'h00050, 8'h05, 0, 20'h00999, 0, 1, 1, ix);
    put(0, 4'd3, 20'h00050, 8'h05, 0, 20'h00333, 0, 1, 1, ix);
    look(32'h0005_0777, 0, "R10 multi");

    // R9 counter sequence with wired 4
    set_wired(4'd4);
    @(negedge clk); prev = rand_idx;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk(rand_idx === ((prev <= 4'd4) ? 4'd15 : prev - 4'd1), "R9 rand sequence",
          64'(rand_idx), 64'((prev <= 4'd4) ? 4'd15 : prev - 4'd1));
      prev = rand_idx;
    end
    // R9 random write lands at sampled index
    put(1, 4'd0, 20'h00060, 8'h05, 0, 20'h00666, 0, 1, 1, ix);
    look(32'h0006_0001, 0, "R9 random write hit");
    put(0, ix, 20'h00061, 8'h05, 0, 20'h00667, 0, 1, 1, ix);
    look(32'h0006_0002, 0, "R9 random target overwritten");

    // constrained random phase
    for (int k = 0; k < 600; k++) begin
      int op = $urandom_range(0, 99);
      logic [19:0] vp = 20'($urandom_range(0, 7)) | 20'h00100;
      if (op < 25)
        put(0, 4'($urandom_range(0, 15)), vp, 8'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0),
            20'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 4) != 0), ix);
      else if (op < 35)
        put(1, 4'd0, vp, 8'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0),
            20'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 4) != 0), ix);
      else if (op < 40)
        set_asid(8'($urandom_range(0, 3)));
      else
        look({vp, 12'($urandom)}, 1'($urandom), "rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule